// File: doc/BRIEF.md
# Console Bus Address Decoder

This block decides where each transaction from the console's parallel bus goes inside the cartridge. On the cycle that a transaction starts, it looks at the top 16 bits of the start address and at a set of configuration switches. From these it picks a target bus (memory or register), a device code, a translated internal address, and a write permit. The result is held until the next transaction starts, so a burst that runs past a 64 kiB boundary keeps the target it was given at its start.

Several windows overlap, and some switches change what a range means. These cases are settled by a fixed priority: the unlocked cartridge window first, then the ROM shadow, then the boot image or the ROM, then the extended ROM, the save windows and the disk-drive windows. A start address that falls in no enabled window selects nothing. The read data returned to the console then comes from whichever bus was selected, or is zero when no bus was selected.

Top module: `pi_addr_decode`

## Requirements
- R1: Reset leaves dev_o=0, both bus selects low, int_addr_o=0 and write_ok_o=0. A decode is registered on a cycle with start_i high and appears after that clock edge. It then holds while start_i stays low, whatever addr_i does. Device codes are 0 none, 1 SDRAM, 2 flash, 3 block RAM, 4 disk-drive registers, 5 cartridge registers, 6 save controller.
- R2: Only addr_i[31:16] picks the window. Low bits only form the offset, so 0x1FFE_FFFC still goes to the block RAM at internal 0x0500_FFFC.
- R3: With boot_en_i low, pages 0x1000–0x13FF go to SDRAM on the memory bus at internal addr_i[25:0]. The write permit for these pages equals rom_we_i.
- R4: With boot_en_i high, pages 0x1000–0x101D go to flash at internal 0x04E0_0000 + addr_i[20:0], read only. Pages 0x101E–0x13FF then select nothing. Flash is never writable.
- R5: With shadow_en_i high, pages 0x13FE–0x13FF go to flash at 0x04FE_0000 + addr_i[16:0], read only. This mapping wins over R3 and R4.
- R6: With rom_ext_en_i high, pages 0x1400–0x14DF go to flash at 0x0400_0000 + addr_i[23:0], read only. With it low, those pages select nothing.
- R7: Save type is coded 0 none, 1 SRAM, 2 banked SRAM, 3 FlashRAM. SRAM maps pages 0x0800–0x0801 to SDRAM at 0x03FE_0000 + addr_i[16:0], writable.
- R8: Banked SRAM maps page 0x0800+4n (n=0..2) to SDRAM at 0x03FE_0000 + n·0x8000 + addr_i[14:0], writable. Every other save page selects nothing.
- R9: FlashRAM maps pages 0x0800–0x0801 as follows. A read goes to the memory bus, SDRAM device, at 0x03FE_0000 + addr_i[16:0]. A write goes to the register bus, save controller device, at addr_i[16:0]. Both are writable.
- R10: Disk-drive mode is coded 0 off, 1 registers, 2 boot image, 3 full. In modes 2 and 3, pages 0x0600–0x063F go to SDRAM at 0x03BC_0000 + addr_i[21:0], and writes are always refused.
- R11: In modes 1 and 3, page 0x0500 goes to the register bus, disk-drive register device, at addr_i[10:0], writable.
- R12: The cartridge window, pages 0x1FFC–0x1FFF, decodes only while unlocked_i is high. Pages 0x1FFC–0x1FFD go to flash at 0x04FE_0000 + addr_i[16:0], read only. Page 0x1FFE goes to block RAM at 0x0500_0000 + addr_i[15:0], writable. Page 0x1FFF goes to the register bus, cartridge register device, at addr_i[15:0], writable.
- R13: An address that hits no enabled window gives device 0, no bus select, no write permit and internal address 0. rdata_o follows mem_rdata_i when the memory bus is selected, reg_rdata_i when the register bus is selected, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start strobe |
| addr_i | input | 32 | Transaction start address |
| write_i | input | 1 | Transaction is a write |
| dd_mode_i | input | 2 | Disk-drive mode (0 off, 1 regs, 2 boot image, 3 full) |
| save_type_i | input | 2 | Save type (0 none, 1 SRAM, 2 banked, 3 FlashRAM) |
| boot_en_i | input | 1 | Boot image replaces the ROM window |
| shadow_en_i | input | 1 | ROM shadow enabled |
| rom_ext_en_i | input | 1 | Extended ROM enabled |
| rom_we_i | input | 1 | ROM window writable |
| unlocked_i | input | 1 | Cartridge register window unlocked |
| mem_rdata_i | input | DATA_W | Read data from the memory bus |
| reg_rdata_i | input | DATA_W | Read data from the register bus |
| mem_sel_o | output | 1 | Memory bus selected |
| reg_sel_o | output | 1 | Register bus selected |
| dev_o | output | 3 | Device code |
| int_addr_o | output | 27 | Translated internal address |
| write_ok_o | output | 1 | Write permitted to the selected target |
| rdata_o | output | DATA_W | Read data returned to the console |

## Verification
The hardest cases are the overlaps, where the same address means different things depending on the switches. Examples are a shadow page with the boot image on and with it off, and an aliased half of a banked save page. The stimulus sends one address several times while changing only one switch between sends. A FlashRAM page is sent both as a read and as a write, to see the bus flip. Holding is checked by moving addr_i across window limits while start_i stays low, after a decode at the last word of a block RAM page.

// File: rtl/pi_dec_pkg.sv
package pi_dec_pkg;
  localparam int INT_W  = 27;
  localparam int NBANK  = 3;
  localparam int NWIN   = 11 + NBANK;

  // window index = priority (lower wins)
  localparam int W_CFLASH = 0;
  localparam int W_CBRAM  = 1;
  localparam int W_CREG   = 2;
  localparam int W_SHADOW = 3;
  localparam int W_BOOT   = 4;
  localparam int W_ROM    = 5;
  localparam int W_ROMEXT = 6;
  localparam int W_SRAM   = 7;
  localparam int W_BANK0  = 8;
  localparam int W_FRAM   = W_BANK0 + NBANK;
  localparam int W_IPL    = W_FRAM + 1;
  localparam int W_DDREG  = W_IPL + 1;

  localparam logic [INT_W-1:0] SHADOW_BASE = 27'h04FE_0000;
  localparam logic [INT_W-1:0] BOOT_BASE   = 27'h04E0_0000;
  localparam logic [INT_W-1:0] EXT_BASE    = 27'h0400_0000;
  localparam logic [INT_W-1:0] SAVE_BASE   = 27'h03FE_0000;
  localparam logic [INT_W-1:0] IPL_BASE    = 27'h03BC_0000;
  localparam logic [INT_W-1:0] BUF_BASE    = 27'h0500_0000;
  localparam logic [INT_W-1:0] BANK_SPAN   = 27'h0000_8000;

  typedef enum logic [1:0] {DD_OFF, DD_REGS, DD_IPL, DD_FULL} dd_mode_e;
  typedef enum logic [1:0] {SV_NONE, SV_SRAM, SV_BANKED, SV_FLASHRAM} save_e;
  typedef enum logic [2:0] {
    DEV_NONE, DEV_SDRAM, DEV_FLASH, DEV_BRAM, DEV_DD_REGS, DEV_CART_REGS, DEV_SAVE_CTRL
  } dev_e;

  typedef struct packed {
    logic             mem;
    logic             regb;
    dev_e             dev;
    logic [INT_W-1:0] iaddr;
    logic             wok;
  } dec_t;

  function automatic dec_t mk_dec(logic mem, logic regb, dev_e dev,
                                  logic [INT_W-1:0] iaddr, logic wok);
    dec_t d;
    d.mem   = mem;
    d.regb  = regb;
    d.dev   = dev;
    d.iaddr = iaddr;
    d.wok   = wok;
    return d;
  endfunction
endpackage

// File: rtl/pi_win_match.sv
module pi_win_match
  import pi_dec_pkg::*;
(
  input  logic [31:0]     addr_i,
  input  logic            write_i,
  input  dd_mode_e        dd_mode_i,
  input  save_e           save_i,
  input  logic            boot_en_i,
  input  logic            shadow_en_i,
  input  logic            rom_ext_en_i,
  input  logic            rom_we_i,
  input  logic            unlocked_i,
  output logic [NWIN-1:0] hit_o,
  output dec_t            win_o [NWIN]
);
  logic [15:0] pg;
  logic        dd_ipl, dd_reg;

  assign pg     = addr_i[31:16];
  assign dd_ipl = (dd_mode_i == DD_IPL)  || (dd_mode_i == DD_FULL);
  assign dd_reg = (dd_mode_i == DD_REGS) || (dd_mode_i == DD_FULL);

  always_comb begin
    hit_o = '0;
    for (int i = 0; i < NWIN; i++) win_o[i] = '0;

    // cartridge window, gated by unlock
    hit_o[W_CFLASH] = unlocked_i && (pg[15:1] == 15'h0FFE);
    win_o[W_CFLASH] = mk_dec(1'b1, 1'b0, DEV_FLASH, SHADOW_BASE + INT_W'(addr_i[16:0]), 1'b0);
    hit_o[W_CBRAM]  = unlocked_i && (pg == 16'h1FFE);
    win_o[W_CBRAM]  = mk_dec(1'b1, 1'b0, DEV_BRAM, BUF_BASE + INT_W'(addr_i[15:0]), 1'b1);
    hit_o[W_CREG]   = unlocked_i && (pg == 16'h1FFF);
    win_o[W_CREG]   = mk_dec(1'b0, 1'b1, DEV_CART_REGS, INT_W'(addr_i[15:0]), 1'b1);

    // ROM area: shadow > boot image / ROM
    hit_o[W_SHADOW] = shadow_en_i && (pg[15:1] == 15'h09FF);
    win_o[W_SHADOW] = mk_dec(1'b1, 1'b0, DEV_FLASH, SHADOW_BASE + INT_W'(addr_i[16:0]), 1'b0);
    hit_o[W_BOOT]   = boot_en_i && (pg >= 16'h1000) && (pg < 16'h101E);
    win_o[W_BOOT]   = mk_dec(1'b1, 1'b0, DEV_FLASH, BOOT_BASE + INT_W'(addr_i[20:0]), 1'b0);
    hit_o[W_ROM]    = !boot_en_i && (pg[15:10] == 6'b000100);
    win_o[W_ROM]    = mk_dec(1'b1, 1'b0, DEV_SDRAM, INT_W'(addr_i[25:0]), rom_we_i);
    hit_o[W_ROMEXT] = rom_ext_en_i && (pg >= 16'h1400) && (pg < 16'h14E0);
    win_o[W_ROMEXT] = mk_dec(1'b1, 1'b0, DEV_FLASH, EXT_BASE + INT_W'(addr_i[23:0]), 1'b0);

    // save area
    hit_o[W_SRAM]   = (save_i == SV_SRAM) && (pg[15:1] == 15'h0400);
    win_o[W_SRAM]   = mk_dec(1'b1, 1'b0, DEV_SDRAM, SAVE_BASE + INT_W'(addr_i[16:0]), 1'b1);
    for (int b = 0; b < NBANK; b++) begin
      hit_o[W_BANK0+b] = (save_i == SV_BANKED) && (pg == 16'h0800 + 16'(4*b));
      win_o[W_BANK0+b] = mk_dec(1'b1, 1'b0, DEV_SDRAM,
                                SAVE_BASE + INT_W'(b) * BANK_SPAN + INT_W'(addr_i[14:0]), 1'b1);
    end
    hit_o[W_FRAM]   = (save_i == SV_FLASHRAM) && (pg[15:1] == 15'h0400);
    win_o[W_FRAM]   = write_i
                    ? mk_dec(1'b0, 1'b1, DEV_SAVE_CTRL, INT_W'(addr_i[16:0]), 1'b1)
                    : mk_dec(1'b1, 1'b0, DEV_SDRAM, SAVE_BASE + INT_W'(addr_i[16:0]), 1'b1);

    // disk drive
    hit_o[W_IPL]    = dd_ipl && (pg[15:6] == 10'h018);
    win_o[W_IPL]    = mk_dec(1'b1, 1'b0, DEV_SDRAM, IPL_BASE + INT_W'(addr_i[21:0]), 1'b0);
    hit_o[W_DDREG]  = dd_reg && (pg == 16'h0500);
    win_o[W_DDREG]  = mk_dec(1'b0, 1'b1, DEV_DD_REGS, INT_W'(addr_i[10:0]), 1'b1);
  end
endmodule

// File: rtl/pi_prio_sel.sv
module pi_prio_sel
  import pi_dec_pkg::*;
#(
  parameter int N = NWIN
) (
  input  logic [N-1:0] hit_i,
  input  dec_t         win_i [N],
  output dec_t         dec_o
);
  always_comb begin
    dec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) dec_o = win_i[i];
    end
  end
endmodule

// File: rtl/pi_rdata_mux.sv
module pi_rdata_mux #(
  parameter int DATA_W = 32
) (
  input  logic              mem_sel_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (mem_sel_i)      rdata_o = mem_rdata_i;
    else if (reg_sel_i) rdata_o = reg_rdata_i;
  end
endmodule

// File: rtl/pi_addr_decode.sv
module pi_addr_decode
  import pi_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       addr_i,
  input  logic              write_i,
  input  logic [1:0]        dd_mode_i,
  input  logic [1:0]        save_type_i,
  input  logic              boot_en_i,
  input  logic              shadow_en_i,
  input  logic              rom_ext_en_i,
  input  logic              rom_we_i,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              mem_sel_o,
  output logic              reg_sel_o,
  output logic [2:0]        dev_o,
  output logic [INT_W-1:0]  int_addr_o,
  output logic              write_ok_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NWIN-1:0] hit;
  dec_t            win [NWIN];
  dec_t            dec_d, dec_q;

  pi_win_match i_match (
    .addr_i      (addr_i),
    .write_i     (write_i),
    .dd_mode_i   (dd_mode_e'(dd_mode_i)),
    .save_i      (save_e'(save_type_i)),
    .boot_en_i   (boot_en_i),
    .shadow_en_i (shadow_en_i),
    .rom_ext_en_i(rom_ext_en_i),
    .rom_we_i    (rom_we_i),
    .unlocked_i  (unlocked_i),
    .hit_o       (hit),
    .win_o       (win)
  );

  pi_prio_sel #(.N(NWIN)) i_prio (
    .hit_i(hit),
    .win_i(win),
    .dec_o(dec_d)
  );

  // selection is taken once per transaction and held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dec_q <= '0;
    else if (start_i) dec_q <= dec_d;
  end

  assign mem_sel_o  = dec_q.mem;
  assign reg_sel_o  = dec_q.regb;
  assign dev_o      = dec_q.dev;
  assign int_addr_o = dec_q.iaddr;
  assign write_ok_o = dec_q.wok;

  pi_rdata_mux #(.DATA_W(DATA_W)) i_rmux (
    .mem_sel_i  (dec_q.mem),
    .reg_sel_i  (dec_q.regb),
    .mem_rdata_i(mem_rdata_i),
    .reg_rdata_i(reg_rdata_i),
    .rdata_o    (rdata_o)
  );

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(dev_o) && $stable(int_addr_o) && $stable(write_ok_o));
  assert_bus_onehot_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_sel_o, reg_sel_o}));
  assert_none_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_o == DEV_NONE) |-> !mem_sel_o && !reg_sel_o && !write_ok_o && (int_addr_o == '0));
  assert_flash_ro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_o == DEV_FLASH) |-> !write_ok_o);
  assert_ipl_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (addr_i[31:22] == 10'h018) |=> !write_ok_o);
  assert_locked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !unlocked_i && (addr_i[31:18] == 14'h07FF) |=> dev_o == DEV_NONE);
  assert_reg_dev_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_o |-> (dev_o == DEV_DD_REGS) || (dev_o == DEV_CART_REGS) || (dev_o == DEV_SAVE_CTRL));
endmodule

// File: tb/test_pi_addr_decode.sv
`timescale 1ns/1ps
module test_pi_addr_decode;
  localparam logic [31:0] MEM_D = 32'hA5A5_0001;
  localparam logic [31:0] REG_D = 32'h5A5A_0002;

  typedef struct {
    logic        mem;
    logic        rg;
    logic [2:0]  dev;
    logic [26:0] ia;
    logic        wok;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  dd = 2'd0;
  logic [1:0]  sv = 2'd0;
  logic        boot = 1'b0, shadow = 1'b0, rext = 1'b0, rwe = 1'b0, unl = 1'b0;
  logic        mem_sel, reg_sel, wok;
  logic [2:0]  dev;
  logic [26:0] ia;
  logic [31:0] rdata;

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  exp_t sb_q[$];
  exp_t last;

  always #2 clk = ~clk;

  pi_addr_decode i_pi_addr_decode (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .write_i(wr),
    .dd_mode_i(dd), .save_type_i(sv), .boot_en_i(boot), .shadow_en_i(shadow),
    .rom_ext_en_i(rext), .rom_we_i(rwe), .unlocked_i(unl),
    .mem_rdata_i(MEM_D), .reg_rdata_i(REG_D),
    .mem_sel_o(mem_sel), .reg_sel_o(reg_sel), .dev_o(dev), .int_addr_o(ia),
    .write_ok_o(wok), .rdata_o(rdata)
  );

  function automatic exp_t mk(logic m, logic r, logic [2:0] d, logic [26:0] a, logic w, string tag);
    exp_t e;
    e.mem = m; e.rg = r; e.dev = d; e.ia = a; e.wok = w; e.tag = tag;
    e.rd = m ? MEM_D : (r ? REG_D : 32'h0);
    return e;
  endfunction

  // reference decode built from the requirement list
  function automatic exp_t model(logic [31:0] a, logic w, string tag);
    logic [15:0] p = a[31:16];
    if (unl && p >= 16'h1FFC && p <= 16'h1FFD) return mk(1, 0, 2, 27'h04FE_0000 + a[16:0], 0, tag);
    if (unl && p == 16'h1FFE) return mk(1, 0, 3, 27'h0500_0000 + a[15:0], 1, tag);
    if (unl && p == 16'h1FFF) return mk(0, 1, 5, 27'(a[15:0]), 1, tag);
    if (shadow && (p == 16'h13FE || p == 16'h13FF)) return mk(1, 0, 2, 27'h04FE_0000 + a[16:0], 0, tag);
    if (p >= 16'h1000 && p <= 16'h13FF) begin
      if (!boot) return mk(1, 0, 1, 27'(a[25:0]), rwe, tag);
      if (p <= 16'h101D) return mk(1, 0, 2, 27'h04E0_0000 + a[20:0], 0, tag);
      return mk(0, 0, 0, 0, 0, tag);
    end
    if (rext && p >= 16'h1400 && p <= 16'h14DF) return mk(1, 0, 2, 27'h0400_0000 + a[23:0], 0, tag);
    if (sv == 2'd1 && (p == 16'h0800 || p == 16'h0801)) return mk(1, 0, 1, 27'h03FE_0000 + a[16:0], 1, tag);
    if (sv == 2'd2 && (p == 16'h0800 || p == 16'h0804 || p == 16'h0808))
      return mk(1, 0, 1, 27'h03FE_0000 + 27'((p - 16'h0800) / 4) * 27'h8000 + a[14:0], 1, tag);
    if (sv == 2'd3 && (p == 16'h0800 || p == 16'h0801))
      return w ? mk(0, 1, 6, 27'(a[16:0]), 1, tag) : mk(1, 0, 1, 27'h03FE_0000 + a[16:0], 1, tag);
    if (dd[1] && p >= 16'h0600 && p <= 16'h063F) return mk(1, 0, 1, 27'h03BC_0000 + a[21:0], 0, tag);
    if ((dd == 2'd1 || dd == 2'd3) && p == 16'h0500) return mk(0, 1, 4, 27'(a[10:0]), 1, tag);
    return mk(0, 0, 0, 0, 0, tag);
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (mem_sel !== e.mem || reg_sel !== e.rg || dev !== e.dev || ia !== e.ia ||
        wok !== e.wok || rdata !== e.rd) begin
      n_bad++;
      $display("FAIL %s: got mem=%0b reg=%0b dev=%0d ia=%h wok=%0b rd=%h exp mem=%0b reg=%0b dev=%0d ia=%h wok=%0b rd=%h",
               e.tag, mem_sel, reg_sel, dev, ia, wok, rdata,
               e.mem, e.rg, e.dev, e.ia, e.wok, e.rd);
    end
  endtask

  task automatic send(logic [31:0] a, logic w, string tag);
    @(negedge clk);
    addr = a; wr = w; start = 1'b1;
    last = model(a, w, tag);
    sb_q.push_back(last);
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // monitor: one compare per captured start, sampled at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (start && rst_n) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R1: decode with no expectation");
        end else compare(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(mk(0, 0, 0, 0, 0, "R1 reset"));
    rst_n = 1'b1;
    @(negedge clk);

    // R3 ROM in SDRAM
    send(32'h1012_3456, 1, "R3 rom ro");
    rwe = 1; send(32'h13AB_CDEF, 1, "R3 rom rw"); rwe = 0;
    // R4 boot image
    boot = 1;
    send(32'h1001_0010, 0, "R4 boot");
    send(32'h101D_FFFC, 1, "R4 boot top");
    send(32'h101E_0000, 0, "R4 past boot");
    // R5 shadow priority
    shadow = 1;
    send(32'h13FF_0004, 0, "R5 shadow over boot");
    boot = 0;
    send(32'h13FE_8000, 1, "R5 shadow over rom");
    shadow = 0;
    send(32'h13FE_8000, 0, "R5 shadow off");
    // R6 extended
    send(32'h1456_789A, 0, "R6 ext off");
    rext = 1;
    send(32'h1456_789A, 1, "R6 ext");
    send(32'h14E0_0000, 0, "R6 ext end");
    rext = 0;
    // R7 SRAM
    sv = 2'd1;
    send(32'h0801_2345, 1, "R7 sram");
    send(32'h0802_0000, 0, "R7 sram end");
    // R8 banked
    sv = 2'd2;
    send(32'h0804_1234, 1, "R8 bank1");
    send(32'h0808_7FFF, 0, "R8 bank2");
    send(32'h0808_8001, 0, "R8 bank2 alias");
    send(32'h0801_0000, 0, "R8 gap");
    send(32'h080C_0000, 0, "R8 beyond");
    // R9 FlashRAM
    sv = 2'd3;
    send(32'h0800_0100, 0, "R9 fram read");
    send(32'h0800_0100, 1, "R9 fram write");
    sv = 2'd0;
    send(32'h0800_0100, 0, "R13 no save");
    // R10 IPL, R11 dd regs
    dd = 2'd1;
    send(32'h0612_3456, 1, "R10 ipl off");
    send(32'h0500_0404, 1, "R11 ddreg");
    dd = 2'd2;
    send(32'h0612_3456, 1, "R10 ipl");
    send(32'h0500_0404, 0, "R11 ddreg off");
    dd = 2'd3;
    send(32'h063F_FFFC, 0, "R10 ipl full");
    send(32'h0500_0010, 0, "R11 ddreg full");
    dd = 2'd0;
    // R12 cartridge window
    send(32'h1FFE_0010, 0, "R12 locked");
    unl = 1;
    send(32'h1FFE_0010, 1, "R12 bram");
    send(32'h1FFF_0008, 1, "R12 regs");
    send(32'h1FFD_0000, 1, "R12 flash");
    // R2 low bits do not steer
    send(32'h1FFE_FFFC, 0, "R2 page top");
    // R1 hold while start low
    @(negedge clk);
    addr = 32'h1FFF_0000; wr = 1;
    repeat (3) @(negedge clk);
    compare(last.tag == "" ? last : mk(last.mem, last.rg, last.dev, last.ia, last.wok, "R1 hold"));
    unl = 0;
    // R13 unmapped
    send(32'h0000_0000, 0, "R13 unmapped");
    send(32'h2000_0000, 1, "R13 high");
    repeat (3) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule